// File: doc/BRIEF.md
# Parallel Configuration Load Sequencer

This block runs the full pin sequence that loads a configuration image into a programmable logic device over a parallel port. A single start pulse makes it select the device for writing and hold the device's configuration reset low for a programmable number of cycles. It then waits for the device to report that it is ready, and streams payload words onto a 16-bit data bus, one word per rising edge of a configuration clock it generates. When the payload has gone out, it checks that the device has reported no error, polls the completion input under a timeout, and sends a fixed number of trailing clock pulses so the device can finish its startup.

Payload words come in through a valid/ready handshake. If the source stalls, the configuration clock stays low. The run ends in one of two terminal states, success or failure, and stays there until the next start. In both terminal states the device is deselected.

Top module: `cfg_load_seq`

## Requirements
- R1: When a start with a supported width is accepted, the first busy cycle shows `prog_n_o`=1, `sel_n_o`=0 and `wr_n_o`=0. When not busy, all three are 1.
- R2: In the cycle after that first busy cycle, `prog_n_o` goes low. It stays low for exactly RST_CYC cycles and then returns high.
- R3: `cfg_clk_o` stays low until `dev_ready_i` is sampled high after the reset pulse. If `dev_ready_i` is not seen high within INIT_TO cycles, the run ends in failure.
- R4: Each payload word is taken when `word_valid_i` and `word_ready_o` are both high. The taken word appears on `cfg_data_o` with `cfg_clk_o` low, and the clock rises in the next cycle. `cfg_data_o` never changes while `cfg_clk_o` is high. A stalled source holds the clock low. Exactly `len_i` words are sent, and zero is allowed.
- R5: The lower byte of `word_i` is the earlier byte of the stream and is driven on `cfg_data_o[15:8]`. The upper byte goes on `cfg_data_o[7:0]`.
- R6: A start with `bus_bytes_i` other than 2 ends in failure in the next cycle, and no device pin leaves its idle level.
- R7: One cycle after the last word's clock pulse, `dev_ready_i` is sampled. If it is low, the run fails.
- R8: `dev_done_i` is polled for at most DONE_TO cycles. If it never goes high in that window, the run fails.
- R9: Once `dev_done_i` is seen, exactly 8 more `cfg_clk_o` pulses follow (one cycle high, one cycle low each), and then `ok_o` is raised.
- R10: At most one of `busy_o`, `ok_o` and `fail_o` is high at a time. A start pulse while busy has no effect.
- R11: After reset the block is idle: all select and reset pins are high, the clock is low, the data bus is zero, and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (taken when not busy) |
| bus_bytes_i | input | 3 | Requested bus width in bytes; only 2 is supported |
| len_i | input | LEN_W | Number of payload words, sampled when data transfer begins |
| word_i | input | DATA_W | Payload word, earlier stream byte in the low byte |
| word_valid_i | input | 1 | Payload word valid |
| word_ready_o | output | 1 | Sequencer takes a word this cycle |
| dev_ready_i | input | 1 | Device initialised (high) or error/busy (low) |
| dev_done_i | input | 1 | Device configuration complete |
| prog_n_o | output | 1 | Device configuration reset, active low |
| sel_n_o | output | 1 | Device select, active low |
| wr_n_o | output | 1 | Transfer direction, low for write |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | DATA_W | Configuration data bus |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |

## Verification
The corners that are hardest to reach depend on when the device model reacts, relative to the last data clock. One is the device dropping its ready line in the single cycle between the final payload pulse and the error check. Another is completion arriving near the end of the poll window. The bench device model counts rising edges of the configuration clock to find the end of the payload and times its responses from there, with delays chosen per run. A stalling source with gaps, a zero-length payload and a start pulse issued during the reset phase complete the set.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RESET,
    ST_WAIT,
    ST_SHIFT,
    ST_CHECK,
    ST_POLL,
    ST_TRAIL,
    ST_OK,
    ST_FAIL
  } seq_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + W'(1);
  end

  assign hit_o = (cnt_q == limit_i - W'(1));

endmodule

// File: rtl/cfg_seq_shift.sv
module cfg_seq_shift #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              active_i,
  input  logic              trail_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              cfg_clk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              done_o
);

  localparam int NB = DATA_W / 8;

  logic [LEN_W-1:0]  left_q;
  logic              pend_q;
  logic              clk_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] word_sw;
  logic              take;

  // earliest stream byte (lowest in word) goes on the top lines
  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign word_sw[(NB-1-b)*8 +: 8] = word_i[b*8 +: 8];
  end

  assign word_ready_o = active_i && !pend_q && (left_q != '0);
  assign done_o       = active_i && !pend_q && (left_q == '0);
  assign take         = word_valid_i && word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      pend_q <= 1'b0;
      clk_q  <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      pend_q <= 1'b0;
      clk_q  <= 1'b0;
    end else if (trail_i) begin
      clk_q  <= ~clk_q;
    end else if (active_i) begin
      if (pend_q) begin
        clk_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (take) begin
        data_q <= word_sw;
        clk_q  <= 1'b0;
        pend_q <= 1'b1;
        left_q <= left_q - LEN_W'(1);
      end else begin
        clk_q  <= 1'b0;
      end
    end else begin
      clk_q  <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  assign cfg_clk_o  = clk_q;
  assign cfg_data_o = data_q;

  p_data_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clk_o |-> $stable(cfg_data_o));

  p_take_then_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (!cfg_clk_o ##1 cfg_clk_o));

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 16,
  parameter int RST_CYC = 4_000_000,
  parameter int INIT_TO = 1_000_000,
  parameter int DONE_TO = 1_000_000,
  parameter int TRAIL_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        bus_bytes_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic              dev_ready_i,
  input  logic              dev_done_i,
  output logic              prog_n_o,
  output logic              sel_n_o,
  output logic              wr_n_o,
  output logic              cfg_clk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_o
);

  localparam int BUS_BYTES = DATA_W / 8;
  localparam int LIM_MAX   = max_of(max_of(RST_CYC, INIT_TO), max_of(DONE_TO, 2 * TRAIL_N));
  localparam int CNT_W     = $clog2(LIM_MAX + 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] limit;
  logic             hit;
  logic             sh_done;
  logic             idle_like;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_OK) || (st_q == ST_FAIL);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_OK, ST_FAIL:
        if (start_i) st_d = (bus_bytes_i == 3'(BUS_BYTES)) ? ST_SETUP : ST_FAIL;
      ST_SETUP: st_d = ST_RESET;
      ST_RESET: if (hit) st_d = ST_WAIT;
      ST_WAIT: begin
        if (dev_ready_i) st_d = ST_SHIFT;
        else if (hit)    st_d = ST_FAIL;
      end
      ST_SHIFT: if (sh_done) st_d = ST_CHECK;
      ST_CHECK: st_d = dev_ready_i ? ST_POLL : ST_FAIL;
      ST_POLL: begin
        if (dev_done_i) st_d = ST_TRAIL;
        else if (hit)   st_d = ST_FAIL;
      end
      ST_TRAIL: if (hit) st_d = ST_OK;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      ST_RESET: limit = CNT_W'(RST_CYC);
      ST_WAIT:  limit = CNT_W'(INIT_TO);
      ST_POLL:  limit = CNT_W'(DONE_TO);
      ST_TRAIL: limit = CNT_W'(2 * TRAIL_N);
      default:  limit = '1;
    endcase
  end

  cfg_seq_timer #(.W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != st_d),
    .limit_i (limit),
    .hit_o   (hit)
  );

  cfg_seq_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       ((st_q == ST_WAIT) && (st_d == ST_SHIFT)),
    .active_i     (st_q == ST_SHIFT),
    .trail_i      (st_q == ST_TRAIL),
    .len_i        (len_i),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .cfg_clk_o    (cfg_clk_o),
    .cfg_data_o   (cfg_data_o),
    .done_o       (sh_done)
  );

  assign prog_n_o = (st_q != ST_RESET);
  assign sel_n_o  = idle_like;
  assign wr_n_o   = idle_like;
  assign busy_o   = !idle_like;
  assign ok_o     = (st_q == ST_OK);
  assign fail_o   = (st_q == ST_FAIL);

  // checker-only counters
  logic [CNT_W-1:0] low_cnt_q;
  logic [CNT_W-1:0] trail_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q   <= '0;
      trail_cnt_q <= '0;
    end else begin
      low_cnt_q <= prog_n_o ? '0 : low_cnt_q + CNT_W'(1);
      if (st_q == ST_SETUP)                    trail_cnt_q <= '0;
      else if (st_q == ST_TRAIL && cfg_clk_o)  trail_cnt_q <= trail_cnt_q + CNT_W'(1);
    end
  end

  p_reset_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_n_o) |-> (low_cnt_q == CNT_W'(RST_CYC)));

  p_clk_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clk_o |-> (st_q == ST_SHIFT || st_q == ST_TRAIL));

  p_reject_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_like && start_i && bus_bytes_i != 3'(BUS_BYTES))
      |=> (fail_o && prog_n_o && sel_n_o && wr_n_o && !cfg_clk_o));

  p_trail_pulses_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> (trail_cnt_q == CNT_W'(TRAIL_N)));

  p_status_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, ok_o, fail_o}));

endmodule

// File: tb/tb_cfg_load_seq.sv
`timescale 1ns/1ps
module tb_cfg_load_seq;

  localparam int RST_CYC = 10;
  localparam int INIT_TO = 20;
  localparam int DONE_TO = 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bus_bytes = 3'd2;
  logic [15:0] len = '0;
  logic [15:0] word = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic        dev_ready = 1'b1;
  logic        dev_done = 1'b0;
  logic        prog_n, sel_n, wr_n, cfg_clk, busy, ok, fail;
  logic [15:0] cfg_data;

  always #2.5 clk = ~clk;

  cfg_load_seq #(.RST_CYC(RST_CYC), .INIT_TO(INIT_TO), .DONE_TO(DONE_TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bus_bytes_i(bus_bytes),
    .len_i(len), .word_i(word), .word_valid_i(word_valid), .word_ready_o(word_ready),
    .dev_ready_i(dev_ready), .dev_done_i(dev_done), .prog_n_o(prog_n), .sel_n_o(sel_n),
    .wr_n_o(wr_n), .cfg_clk_o(cfg_clk), .cfg_data_o(cfg_data), .busy_o(busy),
    .ok_o(ok), .fail_o(fail)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, nm, $time, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic        e_prog = 1, e_sel = 1, e_wr = 1, e_clk = 0, e_ready = 0;
  logic        e_busy = 0, e_ok = 0, e_fail = 0;
  logic [15:0] e_data = '0;

  task automatic m_end(input logic good);
    e_prog = 1; e_sel = 1; e_wr = 1; e_clk = 0; e_ready = 0;
    e_busy = 0; e_ok = good; e_fail = !good;
  endtask

  task automatic m_run();
    int k;
    int w;
    e_prog = 1; e_sel = 0; e_wr = 0; e_busy = 1; e_ok = 0; e_fail = 0; e_ready = 0;
    @(posedge clk); e_prog = 0;
    repeat (RST_CYC) @(posedge clk);
    e_prog = 1;
    k = 0;
    forever begin
      @(posedge clk);
      if (dev_ready) break;
      if (k == INIT_TO - 1) begin m_end(0); return; end
      k++;
    end
    w = 0;
    e_ready = (len != 0);
    while (w < int'(len)) begin
      @(posedge clk);
      if (!word_valid) begin e_clk = 0; continue; end
      e_data = {word[7:0], word[15:8]};
      e_clk = 0; e_ready = 0; w++;
      @(posedge clk);
      e_clk = 1; e_ready = (w < int'(len));
    end
    @(posedge clk); e_clk = 0; e_ready = 0;
    @(posedge clk);
    if (!dev_ready) begin m_end(0); return; end
    k = 0;
    forever begin
      @(posedge clk);
      if (dev_done) break;
      if (k == DONE_TO - 1) begin m_end(0); return; end
      k++;
    end
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); e_clk = 1;
      @(posedge clk); e_clk = 0;
    end
    m_end(1);
  endtask

  initial begin
    wait (rst_n);
    forever begin
      @(posedge clk);
      if (start) begin
        if (bus_bytes != 3'd2) m_end(0);
        else m_run();
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1", "sel_n", sel_n, e_sel);
      chk("R1", "wr_n", wr_n, e_wr);
      chk("R2", "prog_n", prog_n, e_prog);
      chk("R4", "cfg_clk", cfg_clk, e_clk);
      chk("R4", "word_ready", word_ready, e_ready);
      chk("R5", "cfg_data", cfg_data, e_data);
      chk("R10", "busy", busy, e_busy);
      chk("R10", "ok", ok, e_ok);
      chk("R10", "fail", fail, e_fail);
    end
  end

  // ---------------- payload source ----------------
  logic [15:0] src_q[$];
  bit gap_mode = 0;
  bit hs = 0;
  int gcnt = 0;
  always @(posedge clk) hs <= word_valid && word_ready;
  always @(negedge clk) begin
    if (hs && src_q.size() > 0) void'(src_q.pop_front());
    word_valid = (src_q.size() > 0) && (!gap_mode || (gcnt % 3 == 0));
    word = (src_q.size() > 0) ? src_q[0] : 16'h0;
    gcnt++;
  end

  // ---------------- device model ----------------
  int  ph = 0, wcnt = 0, rises = 0, n_words = 0;
  bit  init_en = 1, drop = 0, done_en = 1;
  int  init_dly = 0, done_dly = 0;
  logic clk_prev = 0;
  always @(negedge clk) begin
    if (!prog_n) begin
      dev_ready = 0; dev_done = 0; rises = 0; wcnt = 0; ph = 1;
    end else if (ph == 1) begin
      if (init_en) begin
        if (wcnt == init_dly) begin dev_ready = 1; ph = 2; wcnt = 0; end
        else wcnt++;
      end
    end else if (ph == 2) begin
      if (cfg_clk && !clk_prev) rises++;
      if (rises >= n_words) begin
        if (drop) dev_ready = 0;
        ph = 3;
      end
    end else if (ph == 3) begin
      if (done_en) begin
        if (wcnt == done_dly) begin dev_done = 1; ph = 0; end
        else wcnt++;
      end
    end
    clk_prev = cfg_clk;
  end

  // ---------------- scenarios ----------------
  task automatic run(input string tag, input logic [2:0] bb, input int n, input bit gap,
                     input bit ien, input int idly, input bit drp, input bit den,
                     input int ddly, input bit poke, input bit exp_ok);
    @(negedge clk);
    src_q.delete();
    for (int i = 0; i < n; i++) src_q.push_back(16'h1000 * (n + 1) + 16'h0101 * i + 16'h0013);
    gap_mode = gap; init_en = ien; init_dly = idly; drop = drp;
    done_en = den; done_dly = ddly; n_words = n; len = 16'(n);
    start = 1; bus_bytes = bb;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R10", "busy_after_poke", busy, 1);
    end
    while (busy) @(negedge clk);
    chk(tag, "ok_end", ok, exp_ok);
    chk(tag, "fail_end", fail, !exp_ok);
    chk("R1", "sel_n_end", sel_n, 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "prog_n", prog_n, 1);
    chk("R11", "sel_n", sel_n, 1);
    chk("R11", "wr_n", wr_n, 1);
    chk("R11", "cfg_clk", cfg_clk, 0);
    chk("R11", "cfg_data", cfg_data, 0);
    chk("R11", "status", {busy, ok, fail}, 0);
    cmp_on = 1;
    run("R9", 3'd2, 4, 0, 1, 3, 0, 1, 2,  0, 1);  // nominal
    run("R4", 3'd2, 5, 1, 1, 0, 0, 1, 5,  0, 1);  // stalling source
    run("R6", 3'd1, 2, 0, 1, 0, 0, 1, 0,  0, 0);  // unsupported width
    run("R6", 3'd4, 2, 0, 1, 0, 0, 1, 0,  0, 0);
    run("R3", 3'd2, 2, 0, 0, 0, 0, 1, 0,  0, 0);  // device never ready
    run("R3", 3'd2, 2, 0, 1, INIT_TO - 2, 0, 1, 0, 0, 1); // ready late in window
    run("R7", 3'd2, 3, 0, 1, 2, 1, 1, 0,  0, 0);  // error after payload
    run("R8", 3'd2, 2, 0, 1, 1, 0, 0, 0,  0, 0);  // never done
    run("R8", 3'd2, 2, 0, 1, 1, 0, 1, DONE_TO + 4, 0, 0);
    run("R8", 3'd2, 2, 0, 1, 1, 0, 1, DONE_TO - 6, 0, 1);
    run("R4", 3'd2, 0, 0, 1, 1, 0, 1, 3,  0, 1);  // zero-length payload
    run("R10", 3'd2, 3, 0, 1, 2, 0, 1, 1, 1, 1);  // start while busy
    run("R5", 3'd2, 6, 1, 1, 4, 0, 1, 0,  0, 1);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule